// File: doc/BRIEF.md
# Embedded Controller Host Mailbox

This block is the controller side of a byte-wide mailbox that a host uses to reach a 256-entry internal register space. The host cannot address those registers directly. It writes command bytes to a status/command port and operand bytes to a data port. It paces itself on two handshake flags. The input-full flag shows that a byte it wrote has not yet been taken. The output-full flag shows that a byte is waiting for it on the data port.

A read sequence is a read command followed by one address byte. The addressed register value then appears on the data port with the output-full flag set. A write sequence is a write command, an address byte and a data byte, and the data byte is stored at that address. Two more commands switch burst mode on and off, and burst mode is shown in its own status bit. A query command returns the pending event code. A command byte always starts fresh, so it cancels any sequence that is still waiting for operands.

Top module: `ec_mailbox`

## Requirements
- R1: After reset the status port reads 0x00 and the data port reads 0x00.
- R2: A host write to either port sets the input-full flag (status bit 1) and takes effect on the next clock. Status bit 3 then reads 1 if that write went to the command port (`host_port`=1) and 0 if it went to the data port. When the block is not fetching a register, the flag clears exactly one clock after the write.
- R3: Writing command 0x80 and then one address byte places the register value for that address on the data port. The output-full flag (status bit 0) rises two clocks after the address byte is latched.
- R4: A host read of the data port (`host_rd` with `host_port`=0) clears the output-full flag on the next clock. A read of the status port leaves the flag unchanged.
- R5: Command 0x81, then an address byte, then a data byte issues one register-file write of that data to that address. A later read sequence returns the value.
- R6: Command 0x82 sets the burst bit (status bit 4) and command 0x83 clears it.
- R7: Command 0x84 loads `evt_code` into the data port and sets output-full, so 0x00 is returned when no event is pending. `evt_take` pulses once only when the code is nonzero.
- R8: A command byte that arrives while a read or write sequence is waiting for operands cancels that sequence without any register-file access, and the new command proceeds.
- R9: A data-port byte that arrives with no sequence open is discarded. It causes no register write and does not set output-full.
- R10: An unrecognised command byte leaves the block idle with burst mode unchanged, so a following data byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_port | input | 1 | 0 selects the data port, 1 selects the status/command port |
| host_wr | input | 1 | Host write strobe, one clock per byte |
| host_rd | input | 1 | Host read strobe; a read of the data port consumes the output byte |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte or data-port byte, selected by host_port |
| evt_code | input | 8 | Pending event code, 0x00 when no event is pending |
| evt_take | output | 1 | One-clock pulse when a query delivers a nonzero event code |
| reg_addr | output | 8 | Register-file address |
| reg_rd | output | 1 | Register-file read request; data is expected one clock later |
| reg_wr | output | 1 | Register-file write strobe |
| reg_wdata | output | 8 | Register-file write data |
| reg_rdata | input | 8 | Register-file read data, valid the clock after reg_rd |

## Verification
A sequencer left in the wrong state shows up at the ports within a few clocks. The next data byte then either triggers a register access it should not have, or fails to trigger the one it should. A missing or stray `reg_wr` is caught directly on the register-file port. A wrong sequence state also changes the byte that a later read sequence returns. Flag faults are visible on the status port at exact cycle offsets: input-full must drop one clock after a byte is taken, and output-full must rise two clocks after the address byte. A stuck burst bit, or a query that loses its event code, shows in the first status or data-port read that follows.

// File: rtl/ec_mbox_pkg.sv
package ec_mbox_pkg;

    localparam int BYTE_W = 8;

    // command opcodes
    localparam logic [BYTE_W-1:0] OP_READ    = 8'h80;
    localparam logic [BYTE_W-1:0] OP_WRITE   = 8'h81;
    localparam logic [BYTE_W-1:0] OP_BURST_ON  = 8'h82;
    localparam logic [BYTE_W-1:0] OP_BURST_OFF = 8'h83;
    localparam logic [BYTE_W-1:0] OP_QUERY   = 8'h84;

    // status bit positions
    localparam int ST_OBF   = 0;
    localparam int ST_IBF   = 1;
    localparam int ST_CMD   = 3;
    localparam int ST_BURST = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_RD_ADDR,
        SQ_WR_ADDR,
        SQ_WR_DATA,
        SQ_FETCH
    } seq_state_e;

endpackage

// File: rtl/ec_mbox_hostif.sv
module ec_mbox_hostif
    import ec_mbox_pkg::*;
#(
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_port,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic          consume,
    input  logic          load_out,
    input  logic [DW-1:0] load_data,
    input  logic          burst,
    output logic [DW-1:0] in_byte,
    output logic          in_is_cmd,
    output logic          ibf
);

    typedef struct packed {
        logic [DW-1:0] in_byte;
        logic          in_cmd;
        logic          ibf;
        logic [DW-1:0] out_byte;
        logic          obf;
    } hif_t;

    hif_t hif_d, hif_q;
    logic [DW-1:0] status_w;

    always_comb begin
        hif_d = hif_q;
        if (consume) begin
            hif_d.ibf = 1'b0;
        end
        if (host_wr) begin
            hif_d.in_byte = host_wdata;
            hif_d.in_cmd  = host_port;
            hif_d.ibf     = 1'b1;
        end
        if (host_rd && !host_port) begin
            hif_d.obf = 1'b0;
        end
        if (load_out) begin
            hif_d.out_byte = load_data;
            hif_d.obf      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hif_q <= '0;
        end else begin
            hif_q <= hif_d;
        end
    end

    always_comb begin
        status_w           = '0;
        status_w[ST_OBF]   = hif_q.obf;
        status_w[ST_IBF]   = hif_q.ibf;
        status_w[ST_CMD]   = hif_q.in_cmd;
        status_w[ST_BURST] = burst;
    end

    assign host_rdata = host_port ? status_w : hif_q.out_byte;
    assign in_byte    = hif_q.in_byte;
    assign in_is_cmd  = hif_q.in_cmd;
    assign ibf        = hif_q.ibf;

    AST_WR_SETS_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> ibf); // R2

    AST_DATA_RD_CLEARS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_port && !load_out) |=> !hif_q.obf); // R4

endmodule

// File: rtl/ec_mbox_seq.sv
module ec_mbox_seq
    import ec_mbox_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ibf,
    input  logic [DW-1:0] in_byte,
    input  logic          in_is_cmd,
    input  logic [DW-1:0] evt_code,
    input  logic [DW-1:0] reg_rdata,
    output logic          consume,
    output logic          load_out,
    output logic [DW-1:0] load_data,
    output logic          burst,
    output logic          evt_take,
    output logic [AW-1:0] reg_addr,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata
);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic          burst;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        consume   = 1'b0;
        load_out  = 1'b0;
        load_data = '0;
        evt_take  = 1'b0;
        reg_addr  = seq_q.addr;
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_wdata = in_byte;

        if (seq_q.st == SQ_FETCH) begin
            load_out  = 1'b1;
            load_data = reg_rdata;
            seq_d.st  = SQ_IDLE;
        end else if (ibf) begin
            consume = 1'b1;
            if (in_is_cmd) begin
                seq_d.st = SQ_IDLE;
                case (in_byte)
                    OP_READ:      seq_d.st = SQ_RD_ADDR;
                    OP_WRITE:     seq_d.st = SQ_WR_ADDR;
                    OP_BURST_ON:  seq_d.burst = 1'b1;
                    OP_BURST_OFF: seq_d.burst = 1'b0;
                    OP_QUERY: begin
                        load_out  = 1'b1;
                        load_data = evt_code;
                        evt_take  = (evt_code != '0);
                    end
                    default: ;
                endcase
            end else begin
                case (seq_q.st)
                    SQ_RD_ADDR: begin
                        reg_addr = in_byte[AW-1:0];
                        reg_rd   = 1'b1;
                        seq_d.st = SQ_FETCH;
                    end
                    SQ_WR_ADDR: begin
                        seq_d.addr = in_byte[AW-1:0];
                        seq_d.st   = SQ_WR_DATA;
                    end
                    SQ_WR_DATA: begin
                        reg_wr   = 1'b1;
                        seq_d.st = SQ_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SQ_IDLE, addr: '0, burst: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign burst = seq_q.burst;

    AST_FETCH_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> load_out); // R3

    AST_WR_FROM_DATA_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> (ibf && !in_is_cmd)); // R5

    AST_CMD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (ibf && in_is_cmd) |-> !(reg_wr || reg_rd)); // R8

    AST_TAKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_take |-> (load_out && evt_code != '0)); // R7

endmodule

// File: rtl/ec_mailbox.sv
module ec_mailbox
    import ec_mbox_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_port,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [DW-1:0] evt_code,
    output logic          evt_take,
    output logic [AW-1:0] reg_addr,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata
);

    logic          consume_w;
    logic          load_w;
    logic [DW-1:0] load_data_w;
    logic          burst_w;
    logic [DW-1:0] in_byte_w;
    logic          in_cmd_w;
    logic          ibf_w;

    ec_mbox_hostif #(.DW(DW)) u_hostif (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_port  (host_port),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .consume    (consume_w),
        .load_out   (load_w),
        .load_data  (load_data_w),
        .burst      (burst_w),
        .in_byte    (in_byte_w),
        .in_is_cmd  (in_cmd_w),
        .ibf        (ibf_w)
    );

    ec_mbox_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ibf       (ibf_w),
        .in_byte   (in_byte_w),
        .in_is_cmd (in_cmd_w),
        .evt_code  (evt_code),
        .reg_rdata (reg_rdata),
        .consume   (consume_w),
        .load_out  (load_w),
        .load_data (load_data_w),
        .burst     (burst_w),
        .evt_take  (evt_take),
        .reg_addr  (reg_addr),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata)
    );

    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R5

    AST_IBF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_w && !host_wr) |=> !ibf_w); // R2

endmodule

// File: tb/tb_ec_mailbox.sv
module tb_ec_mailbox;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_port = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] evt_code = 8'h00;
    logic       evt_take;
    logic [7:0] reg_addr;
    logic       reg_rd;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    int total = 0;
    int bad = 0;
    int wr_cnt = 0;
    int take_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ec_mailbox dut (
        .clk(clk), .rst_n(rst_n), .host_port(host_port), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .evt_code(evt_code), .evt_take(evt_take), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // register file model: registered read
    logic [7:0] mem [256];
    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5C);
    end
    always @(posedge clk) begin
        if (reg_wr) mem[reg_addr] <= reg_wdata;
        if (reg_rd) reg_rdata <= mem[reg_addr];
        if (reg_wr) wr_cnt <= wr_cnt + 1;
        if (evt_take) take_cnt <= take_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status();
        return (host_port == 1'b1) ? host_rdata : 8'hxx;
    endfunction

    task automatic peek_status(output logic [7:0] s);
        host_port = 1'b1;
        #1 s = host_rdata;
    endtask

    task automatic peek_data(output logic [7:0] d);
        host_port = 1'b0;
        #1 d = host_rdata;
    endtask

    task automatic host_write(input logic port, input logic [7:0] val);
        @(negedge clk);
        host_port  = port;
        host_wdata = val;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic host_read(input logic port);
        @(negedge clk);
        host_port = port;
        host_rd   = 1'b1;
        @(negedge clk);
        host_rd   = 1'b0;
    endtask

    task automatic wait_flag(input int bitpos, input logic want);
        logic [7:0] s;
        for (int i = 0; i < 20; i++) begin
            peek_status(s);
            if (s[bitpos] == want) return;
            @(negedge clk);
        end
        check("handshake timeout", 0, 1);
    endtask

    task automatic mb_write(input logic [7:0] a, input logic [7:0] v);
        host_write(1'b1, 8'h81); wait_flag(1, 1'b0);
        host_write(1'b0, a);     wait_flag(1, 1'b0);
        host_write(1'b0, v);     wait_flag(1, 1'b0);
        @(negedge clk);
    endtask

    task automatic mb_read(input logic [7:0] a, output logic [7:0] v);
        host_write(1'b1, 8'h80); wait_flag(1, 1'b0);
        host_write(1'b0, a);     wait_flag(0, 1'b1);
        peek_data(v);
        host_read(1'b0);
    endtask

    task automatic t_reset();
        logic [7:0] s, d;
        peek_status(s); check("R1 status", s, 8'h00);
        peek_data(d);   check("R1 data", d, 8'h00);
    endtask

    task automatic t_ibf_and_idle_data();
        logic [7:0] s;
        int w0 = wr_cnt;
        host_write(1'b0, 8'h5A);
        peek_status(s);
        check("R2 ibf set", s[1], 1);
        check("R2 cmd flag 0 on data", s[3], 0);
        @(negedge clk);
        peek_status(s);
        check("R2 ibf clears after one clock", s[1], 0);
        check("R9 idle data no obf", s[0], 0);
        check("R9 idle data no write", wr_cnt, w0);
        host_write(1'b1, 8'h83);
        peek_status(s);
        check("R2 cmd flag 1 on command", s[3], 1);
        wait_flag(1, 1'b0);
    endtask

    task automatic t_write_read();
        logic [7:0] v, s;
        int w0 = wr_cnt;
        mb_write(8'h10, 8'hA5);
        mb_write(8'hFF, 8'h3C);
        check("R5 two register writes", wr_cnt, w0 + 2);
        mb_read(8'h10, v); check("R5 readback 0x10", v, 8'hA5);
        mb_read(8'hFF, v); check("R5 readback 0xFF", v, 8'h3C);
        mb_read(8'h07, v); check("R3 preset value", v, 8'h07 ^ 8'h5C);
        // exact OBF timing
        host_write(1'b1, 8'h80); wait_flag(1, 1'b0);
        host_write(1'b0, 8'h10);
        peek_status(s); check("R3 obf low at latch", s[0], 0);
        @(negedge clk); peek_status(s); check("R3 obf low +1", s[0], 0);
        @(negedge clk); peek_status(s); check("R3 obf high +2", s[0], 1);
        peek_data(v); check("R3 data port", v, 8'hA5);
    endtask

    task automatic t_obf_clear();
        logic [7:0] s;
        host_read(1'b1);
        peek_status(s); check("R4 status read keeps obf", s[0], 1);
        host_read(1'b0);
        peek_status(s); check("R4 data read clears obf", s[0], 0);
    endtask

    task automatic t_burst();
        logic [7:0] s;
        host_write(1'b1, 8'h82); wait_flag(1, 1'b0);
        peek_status(s); check("R6 burst on", s[4], 1);
        host_write(1'b1, 8'h83); wait_flag(1, 1'b0);
        peek_status(s); check("R6 burst off", s[4], 0);
    endtask

    task automatic t_query();
        logic [7:0] s, d;
        int t0 = take_cnt;
        evt_code = 8'h00;
        host_write(1'b1, 8'h84); wait_flag(0, 1'b1);
        peek_data(d); check("R7 empty query", d, 8'h00);
        check("R7 no take when empty", take_cnt, t0);
        host_read(1'b0);
        evt_code = 8'h2B;
        host_write(1'b1, 8'h84); wait_flag(0, 1'b1);
        peek_data(d); check("R7 event code", d, 8'h2B);
        @(negedge clk);
        check("R7 single take", take_cnt, t0 + 1);
        host_read(1'b0);
        evt_code = 8'h00;
        peek_status(s); check("R7 obf cleared", s[0], 0);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        int w0;
        mb_write(8'h20, 8'h11);
        w0 = wr_cnt;
        host_write(1'b1, 8'h81); wait_flag(1, 1'b0);
        host_write(1'b0, 8'h20); wait_flag(1, 1'b0);
        mb_read(8'h20, v);
        check("R8 aborted write no access", wr_cnt, w0);
        check("R8 new read proceeds", v, 8'h11);
        host_write(1'b1, 8'h80); wait_flag(1, 1'b0);
        host_write(1'b1, 8'h81); wait_flag(1, 1'b0);
        host_write(1'b0, 8'h21); wait_flag(1, 1'b0);
        host_write(1'b0, 8'h77); wait_flag(1, 1'b0);
        @(negedge clk);
        mb_read(8'h21, v);
        check("R8 write after aborted read", v, 8'h77);
    endtask

    task automatic t_unknown();
        logic [7:0] s;
        int w0;
        host_write(1'b1, 8'h82); wait_flag(1, 1'b0);
        host_write(1'b1, 8'h80); wait_flag(1, 1'b0);
        host_write(1'b1, 8'h55); wait_flag(1, 1'b0);
        w0 = wr_cnt;
        host_write(1'b0, 8'h30); wait_flag(1, 1'b0);
        repeat (3) @(negedge clk);
        peek_status(s);
        check("R10 data after unknown no obf", s[0], 0);
        check("R10 burst unchanged", s[4], 1);
        check("R10 no write", wr_cnt, w0);
        host_write(1'b1, 8'h83); wait_flag(1, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check("watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ibf_and_idle_data();
        t_write_read();
        t_obf_clear();
        t_burst();
        t_query();
        t_abort();
        t_unknown();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule